// File: doc/BRIEF.md
# Quadrature Encoder Emulator with Zero Marker

This block turns an absolute angle into the signals of an incremental encoder. It takes a position word that moves by at most one LSB per update strobe. From it the block produces two quadrature channels, a direction flag and a zero-crossing marker. These outputs can drive logic that expects an optical encoder. Four position steps make one full quadrature cycle, so a 12-bit angle gives 1024 line cycles per revolution.

Every output comes from a register and changes only on the system clock edge that samples an update strobe. The outputs are therefore glitch-free and always valid. A control half compares each new position with the one it last accepted. It sends a small bundle of strobes (load, moved, stepped up) to a datapath half, which holds the output registers. A 2-bit select sets the marker width to a quarter, a half or a whole quadrature cycle.

Top module: `quad_encoder_emu`

## Requirements
- R1: After reset, chanA=0, chanB=0, dirOut=1 and markOut=0. The last accepted position is taken as 0.
- R2: On the clock edge that samples updStb high, chanA and chanB are loaded from posIn[1:0] as follows: 00 gives A=0,B=0; 01 gives A=1,B=0; 10 gives A=1,B=1; 11 gives A=0,B=1.
- R3: Stepping up one LSB at a time through a whole revolution of a POS_W-bit angle gives 2^POS_W/4 rising edges on chanA. While the angle rises, chanA changes a quarter cycle before chanB.
- R4: On a strobe whose position is the last accepted position plus one (modulo 2^POS_W), dirOut becomes 1. On a strobe with any other changed position, dirOut becomes 0. This includes the step from 0 to the maximum value.
- R5: A strobe that repeats the last accepted position leaves dirOut unchanged.
- R6: markSel encodes the marker width: 00 is 90°, 01 is 180°, 10 is 360°. The value 11 behaves as 90°.
- R7: On a strobe, markOut becomes 1 exactly when posIn is below the selected width in counts (1, 2 or 4), and 0 otherwise.
- R8: Between strobes, all outputs hold their values. A change of markSel without a strobe has no effect on markOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| posIn | input | POS_W | Absolute angle, at most one LSB change per strobe |
| updStb | input | 1 | Position update strobe, one clock wide |
| markSel | input | 2 | Marker width select |
| chanA | output | 1 | Quadrature channel A |
| chanB | output | 1 | Quadrature channel B |
| dirOut | output | 1 | Direction, 1 while the angle increases |
| markOut | output | 1 | Zero-crossing marker |

## Verification
The bench uses the default POS_W of 12. This makes a full revolution of 4096 single-LSB steps short enough to run. The sweep reaches the wrap from 4095 to 0 in both directions and lets the bench count the 1024 channel-A cycles. All four marker select codes are used around position zero. The bench also changes the select with no strobe to show that the marker holds until the next strobe.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef struct packed {
    logic load;
    logic moved;
    logic stepUp;
  } qencStb_t;

  typedef enum logic [1:0] {
    MARK_QUARTER = 2'b00,
    MARK_HALF    = 2'b01,
    MARK_FULL    = 2'b10,
    MARK_SPARE   = 2'b11
  } markSel_e;
endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] posIn,
  input  logic             updStb,
  output qencStb_t         stb
);
  logic [POS_W-1:0] lastPos;
  logic [POS_W-1:0] nextUp;

  assign nextUp = POS_W'(lastPos + 1'b1);

  always_comb begin
    stb.load   = updStb;
    stb.moved  = updStb && (posIn != lastPos);
    stb.stepUp = (posIn == nextUp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lastPos <= '0;
    else if (updStb) lastPos <= posIn;
  end
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] posIn,
  input  logic [1:0]       markSel,
  input  qencStb_t         stb,
  output logic             chanA,
  output logic             chanB,
  output logic             dirOut,
  output logic             markOut
);
  localparam int CYCLE_STEPS = 4;
  localparam int QUARTER     = CYCLE_STEPS / 4;

  logic       nextA, nextB;
  logic [2:0] markSpan;

  always_comb begin
    unique case (posIn[1:0])
      2'b00:   {nextA, nextB} = 2'b00;
      2'b01:   {nextA, nextB} = 2'b10;
      2'b10:   {nextA, nextB} = 2'b11;
      default: {nextA, nextB} = 2'b01;
    endcase
  end

  always_comb begin
    case (markSel_e'(markSel))
      MARK_HALF: markSpan = 3'(2 * QUARTER);
      MARK_FULL: markSpan = 3'(4 * QUARTER);
      default:   markSpan = 3'(QUARTER);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chanA   <= 1'b0;
      chanB   <= 1'b0;
      dirOut  <= 1'b1;
      markOut <= 1'b0;
    end else if (stb.load) begin
      chanA   <= nextA;
      chanB   <= nextB;
      markOut <= (32'(posIn) < 32'(markSpan));
      if (stb.moved) dirOut <= stb.stepUp;
    end
  end
endmodule

// File: rtl/quad_encoder_emu.sv
module quad_encoder_emu
  import qenc_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] posIn,
  input  logic             updStb,
  input  logic [1:0]       markSel,
  output logic             chanA,
  output logic             chanB,
  output logic             dirOut,
  output logic             markOut
);
  qencStb_t stb;

  qenc_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .posIn(posIn), .updStb(updStb), .stb(stb)
  );

  qenc_datapath #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .posIn(posIn), .markSel(markSel), .stb(stb),
    .chanA(chanA), .chanB(chanB), .dirOut(dirOut), .markOut(markOut)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] posIn,
  input logic             updStb,
  input logic [1:0]       markSel,
  input logic             chanA,
  input logic             chanB,
  input logic             dirOut,
  input logic             markOut
);
  logic [1:0] prevLow;
  assign prevLow = {chanB, chanA ^ chanB};

  p_gray_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    updStb |=> (chanA == ($past(posIn[1]) ^ $past(posIn[0]))) && (chanB == $past(posIn[1])));

  p_one_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    updStb |=> ($countones({chanA ^ $past(chanA), chanB ^ $past(chanB)}) <= 1));

  p_dir_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (updStb && posIn[1:0] == 2'(prevLow + 2'd1)) |=> dirOut);

  p_dir_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (updStb && posIn[1:0] == 2'(prevLow - 2'd1)) |=> !dirOut);

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (updStb && posIn[1:0] == prevLow) |=> $stable(dirOut));

  p_mark_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (updStb && posIn == '0) |=> markOut);

  p_mark_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (updStb && 32'(posIn) >= 4) |=> !markOut);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !updStb |=> $stable({chanA, chanB, dirOut, markOut}));
endmodule

bind quad_encoder_emu qenc_checker #(.POS_W(POS_W)) u_chk (.*);

// File: tb/sim_quad_encoder_emu.sv
module sim_quad_encoder_emu;
  localparam int POS_W = 12;
  localparam int REV   = 1 << POS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [POS_W-1:0] posIn = '0;
  logic updStb = 1'b0;
  logic [1:0] markSel = 2'b00;
  logic chanA, chanB, dirOut, markOut;

  int tests = 0, fails = 0;
  int curPos = 0;
  int aRises = 0;
  logic prevA = 1'b0;
  bit done = 1'b0;

  int mA = 0, mB = 0, mDir = 1, mNm = 0, mLast = 0;

  always #2.5 clk = ~clk;

  quad_encoder_emu #(.POS_W(POS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .posIn(posIn), .updStb(updStb), .markSel(markSel),
    .chanA(chanA), .chanB(chanB), .dirOut(dirOut), .markOut(markOut)
  );

  // behavioural reference, updated on each edge from the sampled inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      mA = 0; mB = 0; mDir = 1; mNm = 0; mLast = 0;
    end else if (updStb) begin
      int p, w;
      p = int'(posIn);
      if (p != mLast) mDir = (p == (mLast + 1) % REV) ? 1 : 0;
      mLast = p;
      case (p % 4)
        0: begin mA = 0; mB = 0; end
        1: begin mA = 1; mB = 0; end
        2: begin mA = 1; mB = 1; end
        default: begin mA = 0; mB = 1; end
      endcase
      w = (markSel == 2'b01) ? 2 : (markSel == 2'b10) ? 4 : 1;
      mNm = (p < w) ? 1 : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 chanA", int'(chanA), mA);
      check("R2 chanB", int'(chanB), mB);
      check("R4/R5 dirOut", int'(dirOut), mDir);
      check("R7 markOut", int'(markOut), mNm);
      if (chanA && !prevA) aRises++;
      prevA = chanA;
    end
  end

  task automatic strobeAt(int p);
    @(negedge clk);
    posIn  = POS_W'(p);
    updStb = 1'b1;
    @(negedge clk);
    updStb = 1'b0;
  endtask

  task automatic stepBy(int d);
    curPos = (curPos + d + REV) % REV;
    strobeAt(curPos);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 chanA", int'(chanA), 0);
    check("R1 chanB", int'(chanB), 0);
    check("R1 dirOut", int'(dirOut), 1);
    check("R1 markOut", int'(markOut), 0);

    // R3 full revolution upward
    markSel = 2'b00;
    aRises = 0;
    for (int i = 0; i < REV; i++) stepBy(1);
    @(negedge clk);
    check("R3 A rises per revolution", aRises, REV / 4);
    check("R4 dir after wrap up", int'(dirOut), 1);
    check("R7 marker at zero", int'(markOut), 1);

    // R4 wrap downward, then R5 repeated position
    stepBy(-1);
    @(negedge clk);
    check("R4 dir after wrap down", int'(dirOut), 0);
    for (int i = 0; i < 3; i++) strobeAt(curPos);
    @(negedge clk);
    check("R5 dir held on repeat", int'(dirOut), 0);

    // R6/R7 half width, stepping up across zero
    markSel = 2'b01;
    stepBy(1);
    @(negedge clk);
    check("R4 dir after reversal", int'(dirOut), 1);
    check("R7 half width at 0", int'(markOut), 1);
    stepBy(1);
    @(negedge clk);
    check("R7 half width at 1", int'(markOut), 1);
    stepBy(1);
    @(negedge clk);
    check("R7 half width at 2", int'(markOut), 0);

    // R6/R7 full width, stepping down across zero
    markSel = 2'b10;
    stepBy(1);
    @(negedge clk);
    check("R7 full width at 3", int'(markOut), 1);
    for (int i = 0; i < 8; i++) stepBy(-1);
    stepBy(1);
    stepBy(1);
    @(negedge clk);
    check("R7 full width outside at 4093", int'(markOut), 0);

    // R6 spare code acts as quarter width
    markSel = 2'b11;
    for (int i = 0; i < 4; i++) stepBy(1);
    @(negedge clk);
    check("R6 spare code at 1", int'(markOut), 0);
    stepBy(-1);
    @(negedge clk);
    check("R6 spare code at 0", int'(markOut), 1);

    // R8 select change without strobe has no effect
    markSel = 2'b00;
    stepBy(1);
    stepBy(1);
    @(negedge clk);
    check("R8 marker before select change", int'(markOut), 0);
    markSel = 2'b10;
    repeat (5) @(negedge clk);
    check("R8 marker held without strobe", int'(markOut), 0);
    check("R8 chanA held without strobe", int'(chanA), 1);
    strobeAt(curPos);
    @(negedge clk);
    check("R6 full width applies at next strobe", int'(markOut), 1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule